// File: doc/BRIEF.md
# Bridge Read Prefetch Policy Controller

A master on the downstream conventional bus starts a memory read. This block decides how many bytes the bridge requests upstream for that read. The inputs are the read command (plain, line or multiple), whether the address falls in the prefetchable window, and whether the bus runs in the extended protocol mode. Two mode fields shape the request: one governs plain reads and the other governs line reads. The possible outcomes are a fetch to the end of the current cache line, a full prefetch capped by a coded maximum byte count, or a single DWORD followed by a disconnect.

For line reads, the line-read mode field also sets the retention policy for prefetched data that the master did not consume. That data can be kept when the master ends the burst, or whenever the transfer ends. Kept data is marked valid until a programmable discard timer runs out.

The configuration fields are captured by a load strobe and reset to zero. Each decision is registered and presented one cycle after the request. It is held until the next request.

Top module: `pf_prefetch_ctrl`

## Requirements
- R1: After reset every configuration field is zero, so a prefetchable plain read fetches to the end of its cache line.
- R2: A read whose address is not prefetchable requests 4 bytes, with no disconnect flag and no retention, for any command and any mode.
- R3: A prefetchable plain read with plain mode 2'b00 or the reserved 2'b01 requests LINE_DW*4 - (line_addr mod LINE_DW*4) bytes, which is up to the next line boundary.
- R4: A prefetchable plain read with plain mode 2'b10 requests the decoded maximum byte count. A prefetchable read multiple (cmd 2'b10) always requests the decoded maximum.
- R5: A prefetchable plain read with plain mode 2'b11 requests 4 bytes and raises rsp_disc.
- R6: The maximum count code decodes as 0→512, 1→128, 2→256, 3→512, 4→1024, 5→2048, 6→4096 and 7→512 bytes.
- R7: A prefetchable read line (cmd 2'b01) in conventional mode requests one line with line mode 2'b00, and the maximum with no retention with line mode 2'b10.
- R8: Line mode 2'b01 gives a full prefetch that is retained only on a master-ended transfer (rsp_keep_m=1, rsp_keep_b=0). Line mode 2'b11 gives a full prefetch that is retained on either end (both flags 1).
- R9: In extended mode the line mode field is ignored. A read line is then decided by the plain mode and is never retained.
- R10: A termination that matches the held retention flags (term_by_master=1 with rsp_keep_m, or 0 with rsp_keep_b) sets retained at the next edge. retained stays high for discard_limit+1 cycles and then clears. A termination that does not match leaves retained low.
- R11: rsp_valid pulses for exactly one cycle, one clock after req_valid. The response fields are those computed from that request.
- R12: A configuration load takes effect from the following cycle. A request in the same cycle as the load is decided with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Captures the configuration inputs |
| cfg_line_mode | input | 2 | Line-read prefetch mode |
| cfg_plain_mode | input | 2 | Plain-read prefetch mode |
| cfg_max_code | input | 3 | Maximum read byte count code |
| cfg_discard | input | DISC_W | Discard timer load value |
| req_valid | input | 1 | Start of a downstream memory read |
| req_cmd | input | 2 | 00 plain, 01 line, 10 multiple, 11 treated as plain |
| req_pf_hit | input | 1 | Address is in the prefetchable window |
| req_ext | input | 1 | Bus runs in extended mode |
| line_addr | input | 12 | Low address bits of the read |
| term_valid | input | 1 | Current transfer has ended with data left over |
| term_by_master | input | 1 | 1: master ended it, 0: bridge ended it |
| rsp_valid | output | 1 | Decision pulse |
| rsp_len | output | 13 | Upstream request length in bytes |
| rsp_disc | output | 1 | Disconnect after the first DWORD |
| rsp_keep_m | output | 1 | Leftover kept when the master ends |
| rsp_keep_b | output | 1 | Leftover kept when the bridge ends |
| retained | output | 1 | Retained data still valid |

## Verification
The hardest state to reach is retained data expiring at exactly the right cycle under the right mode. It needs a line read decided in conventional mode under line mode 01 or 11, and then a termination whose initiator matches the held flags. The bench loads a short discard value, issues such a read, and ends it once from each side. It samples retained on every cycle of the window, which catches off-by-one expiry and retention under the wrong initiator. The simultaneous load-and-request case is driven in a single cycle to separate old and new configuration.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam logic [1:0] CMD_PLAIN = 2'b00;
  localparam logic [1:0] CMD_LINE  = 2'b01;
  localparam logic [1:0] CMD_MULTI = 2'b10;

  typedef enum logic [1:0] {
    MODE_ONE_LINE = 2'b00,
    MODE_ALT      = 2'b01,
    MODE_FULL     = 2'b10,
    MODE_SPECIAL  = 2'b11
  } pf_mode_e;

  localparam int LEN_W = 13;

  // Byte cap for a full prefetch
  function automatic logic [LEN_W-1:0] max_bytes(input logic [2:0] code);
    case (code)
      3'd1:    return 13'd128;
      3'd2:    return 13'd256;
      3'd4:    return 13'd1024;
      3'd5:    return 13'd2048;
      3'd6:    return 13'd4096;
      default: return 13'd512;
    endcase
  endfunction

  // Bytes from an address to the next line boundary
  function automatic logic [LEN_W-1:0] to_line_end(input logic [11:0] a, input int lb);
    int rem;
    rem = int'(a) % lb;
    return LEN_W'(lb - rem);
  endfunction
endpackage

// File: rtl/pf_cfg_regs.sv
module pf_cfg_regs #(
  parameter int DISC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        line_mode_i,
  input  logic [1:0]        plain_mode_i,
  input  logic [2:0]        max_code_i,
  input  logic [DISC_W-1:0] discard_i,
  output logic [1:0]        line_mode_q,
  output logic [1:0]        plain_mode_q,
  output logic [2:0]        max_code_q,
  output logic [DISC_W-1:0] discard_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_mode_q  <= '0;
      plain_mode_q <= '0;
      max_code_q   <= '0;
      discard_q    <= '0;
    end else if (load) begin
      line_mode_q  <= line_mode_i;
      plain_mode_q <= plain_mode_i;
      max_code_q   <= max_code_i;
      discard_q    <= discard_i;
    end
  end

  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (plain_mode_q == $past(plain_mode_i)) && (line_mode_q == $past(line_mode_i)));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(max_code_q) && $stable(discard_q));
endmodule

// File: rtl/pf_decide.sv
module pf_decide
  import pf_pkg::*;
#(
  parameter int LINE_DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic             req_pf_hit,
  input  logic             req_ext,
  input  logic [11:0]      line_addr,
  input  logic [1:0]       line_mode,
  input  logic [1:0]       plain_mode,
  input  logic [2:0]       max_code,
  output logic             rsp_valid,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_disc,
  output logic             rsp_keep_m,
  output logic             rsp_keep_b
);
  localparam int LINE_BYTES = LINE_DW * 4;

  logic             line_rule;   // read line governed by the line field
  logic             multi_rule;
  logic [LEN_W-1:0] full_len, one_line_len, nxt_len;
  logic             nxt_disc, nxt_keep_m, nxt_keep_b;

  assign line_rule    = (req_cmd == CMD_LINE) && !req_ext;
  assign multi_rule   = (req_cmd == CMD_MULTI);
  assign full_len     = max_bytes(max_code);
  assign one_line_len = to_line_end(line_addr, LINE_BYTES);

  always_comb begin
    nxt_len    = 13'd4;
    nxt_disc   = 1'b0;
    nxt_keep_m = 1'b0;
    nxt_keep_b = 1'b0;
    if (req_pf_hit) begin
      if (multi_rule) begin
        nxt_len = full_len;
      end else if (line_rule) begin
        case (pf_mode_e'(line_mode))
          MODE_ONE_LINE: nxt_len = one_line_len;
          MODE_ALT:      begin nxt_len = full_len; nxt_keep_m = 1'b1; end
          MODE_FULL:     nxt_len = full_len;
          default:       begin nxt_len = full_len; nxt_keep_m = 1'b1; nxt_keep_b = 1'b1; end
        endcase
      end else begin
        case (pf_mode_e'(plain_mode))
          MODE_FULL:    nxt_len = full_len;
          MODE_SPECIAL: begin nxt_len = 13'd4; nxt_disc = 1'b1; end
          default:      nxt_len = one_line_len;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_len    <= 13'd4;
      rsp_disc   <= 1'b0;
      rsp_keep_m <= 1'b0;
      rsp_keep_b <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_len    <= nxt_len;
        rsp_disc   <= nxt_disc;
        rsp_keep_m <= nxt_keep_m;
        rsp_keep_b <= nxt_keep_b;
      end
    end
  end

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_nonpf_dword_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_pf_hit |=> rsp_len == 13'd4 && !rsp_disc && !rsp_keep_m && !rsp_keep_b);
  p_disc_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_disc |-> rsp_len == 13'd4);
  p_ext_nokeep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ext |=> !rsp_keep_m && !rsp_keep_b);
  p_bridge_implies_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_keep_b |-> rsp_keep_m);
  p_len_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_len <= 13'd4096 && rsp_len != 13'd0);
endmodule

// File: rtl/pf_discard_timer.sv
module pf_discard_timer #(
  parameter int DISC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retain_evt,
  input  logic [DISC_W-1:0] limit,
  output logic              retained
);
  logic [DISC_W-1:0] cnt;
  logic              expire;

  assign expire = retained && (cnt == '0) && !retain_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retained <= 1'b0;
      cnt      <= '0;
    end else if (retain_evt) begin
      retained <= 1'b1;
      cnt      <= limit;
    end else if (retained) begin
      if (cnt == '0) retained <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  p_expire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !retained);
  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    retain_evt |=> retained);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retained) |-> $past(retain_evt));
endmodule

// File: rtl/pf_prefetch_ctrl.sv
module pf_prefetch_ctrl
  import pf_pkg::*;
#(
  parameter int LINE_DW = 8,
  parameter int DISC_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_line_mode,
  input  logic [1:0]        cfg_plain_mode,
  input  logic [2:0]        cfg_max_code,
  input  logic [DISC_W-1:0] cfg_discard,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic              req_pf_hit,
  input  logic              req_ext,
  input  logic [11:0]       line_addr,
  input  logic              term_valid,
  input  logic              term_by_master,
  output logic              rsp_valid,
  output logic [12:0]       rsp_len,
  output logic              rsp_disc,
  output logic              rsp_keep_m,
  output logic              rsp_keep_b,
  output logic              retained
);
  logic [1:0]        line_mode_q, plain_mode_q;
  logic [2:0]        max_code_q;
  logic [DISC_W-1:0] discard_q;
  logic              retain_evt;

  pf_cfg_regs #(.DISC_W(DISC_W)) u_cfg (
    .clk, .rst_n, .load(cfg_load),
    .line_mode_i(cfg_line_mode), .plain_mode_i(cfg_plain_mode),
    .max_code_i(cfg_max_code), .discard_i(cfg_discard),
    .line_mode_q, .plain_mode_q, .max_code_q, .discard_q
  );

  pf_decide #(.LINE_DW(LINE_DW)) u_decide (
    .clk, .rst_n, .req_valid, .req_cmd, .req_pf_hit, .req_ext, .line_addr,
    .line_mode(line_mode_q), .plain_mode(plain_mode_q), .max_code(max_code_q),
    .rsp_valid, .rsp_len, .rsp_disc, .rsp_keep_m, .rsp_keep_b
  );

  // Retention event: the ending side matches the held policy
  assign retain_evt = term_valid && (term_by_master ? rsp_keep_m : rsp_keep_b);

  pf_discard_timer #(.DISC_W(DISC_W)) u_timer (
    .clk, .rst_n, .retain_evt, .limit(discard_q), .retained
  );

  p_wrong_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid && !term_by_master && !rsp_keep_b && !retained |=> !retained);
endmodule

// File: tb/tb_pf_prefetch_ctrl.sv
`timescale 1ns/1ps
module tb_pf_prefetch_ctrl;
  logic clk = 0, rst_n = 0;
  logic cfg_load = 0;
  logic [1:0] cfg_line_mode = 0, cfg_plain_mode = 0;
  logic [2:0] cfg_max_code = 0;
  logic [9:0] cfg_discard = 0;
  logic req_valid = 0, req_pf_hit = 0, req_ext = 0;
  logic [1:0] req_cmd = 0;
  logic [11:0] line_addr = 0;
  logic term_valid = 0, term_by_master = 0;
  logic rsp_valid, rsp_disc, rsp_keep_m, rsp_keep_b, retained;
  logic [12:0] rsp_len;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pf_prefetch_ctrl dut (.*);

  function automatic int exp_max(input int code);
    int tbl[8] = '{512, 128, 256, 512, 1024, 2048, 4096, 512};
    return tbl[code];
  endfunction

  function automatic int exp_line(input int a);
    return 32 - (a & 31);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int lm, input int pm, input int mc, input int dl);
    @(negedge clk);
    cfg_load = 1; cfg_line_mode = 2'(lm); cfg_plain_mode = 2'(pm);
    cfg_max_code = 3'(mc); cfg_discard = 10'(dl);
    @(negedge clk);
    cfg_load = 0;
  endtask

  // Issue one request; on return the response is visible
  task automatic request(input int cmd, input bit pf, input bit ext, input int a);
    @(negedge clk);
    req_valid = 1; req_cmd = 2'(cmd); req_pf_hit = pf; req_ext = ext; line_addr = 12'(a);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_rsp(input string req, input int len, input bit d, input bit km, input bit kb);
    chk({req, " valid"}, rsp_valid, 1);
    chk({req, " len"}, rsp_len, len);
    chk({req, " disc"}, rsp_disc, d);
    chk({req, " keep_m"}, rsp_keep_m, km);
    chk({req, " keep_b"}, rsp_keep_b, kb);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid idle", rsp_valid, 0);
    chk("R1 retained idle", retained, 0);
    request(0, 1, 0, 'h10);
    expect_rsp("R1", 16, 0, 0, 0);
    @(negedge clk);
    chk("R11 single pulse", rsp_valid, 0);
  endtask

  task automatic t_nonpf();
    load_cfg(3, 3, 6, 0);
    for (int c = 0; c < 3; c++) begin
      request(c, 0, 0, 'h40);
      expect_rsp("R2", 4, 0, 0, 0);
    end
  endtask

  task automatic t_plain();
    load_cfg(0, 0, 0, 0);
    request(0, 1, 0, 'h1c);
    expect_rsp("R3 mode00", 4, 0, 0, 0);
    load_cfg(0, 1, 0, 0);
    request(0, 1, 0, 'h04);
    expect_rsp("R3 mode01", 28, 0, 0, 0);
    for (int mc = 0; mc < 8; mc++) begin
      load_cfg(0, 2, mc, 0);
      request(0, 1, 0, 'h08);
      expect_rsp("R4 R6 full", exp_max(mc), 0, 0, 0);
    end
    load_cfg(0, 3, 4, 0);
    request(0, 1, 0, 'h08);
    expect_rsp("R5 disc", 4, 1, 0, 0);
    load_cfg(0, 0, 5, 0);
    request(2, 1, 0, 'h08);
    expect_rsp("R4 multi", exp_max(5), 0, 0, 0);
  endtask

  task automatic t_line();
    load_cfg(0, 3, 1, 0);
    request(1, 1, 0, 'h23);
    expect_rsp("R7 line00", exp_line('h23), 0, 0, 0);
    load_cfg(2, 0, 1, 0);
    request(1, 1, 0, 'h23);
    expect_rsp("R7 line10", 128, 0, 0, 0);
    load_cfg(1, 0, 2, 0);
    request(1, 1, 0, 'h00);
    expect_rsp("R8 line01", 256, 0, 1, 0);
    load_cfg(3, 0, 4, 0);
    request(1, 1, 0, 'h00);
    expect_rsp("R8 line11", 1024, 0, 1, 1);
  endtask

  task automatic t_ext();
    load_cfg(3, 3, 6, 0);
    request(1, 1, 1, 'h00);
    expect_rsp("R9 ext plain11", 4, 1, 0, 0);
    load_cfg(3, 2, 6, 0);
    request(1, 1, 1, 'h00);
    expect_rsp("R9 ext plain10", 4096, 0, 0, 0);
  endtask

  task automatic term_and_watch(input string req, input bit by_m, input bit expect_keep, input int lim);
    @(negedge clk);
    term_valid = 1; term_by_master = by_m;
    @(negedge clk);
    term_valid = 0;
    for (int k = 0; k <= lim; k++) begin
      chk(req, retained, expect_keep ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " expired"}, retained, 0);
  endtask

  task automatic t_timer();
    load_cfg(1, 0, 0, 5);
    request(1, 1, 0, 'h00);
    term_and_watch("R10 mode01 bridge end", 0, 0, 5);
    term_and_watch("R10 mode01 master end", 1, 1, 5);
    load_cfg(3, 0, 0, 3);
    request(1, 1, 0, 'h00);
    term_and_watch("R10 mode11 bridge end", 0, 1, 3);
  endtask

  task automatic t_cfg_timing();
    load_cfg(0, 0, 3, 0);
    @(negedge clk);
    cfg_load = 1; cfg_plain_mode = 2'd2; cfg_max_code = 3'd4;
    req_valid = 1; req_cmd = 0; req_pf_hit = 1; req_ext = 0; line_addr = 12'h08;
    @(negedge clk);
    cfg_load = 0; req_valid = 0;
    chk("R12 same-cycle old cfg", rsp_len, 24);
    request(0, 1, 0, 'h08);
    chk("R12 new cfg", rsp_len, 1024);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_nonpf();
    t_plain();
    t_line();
    t_ext();
    t_timer();
    t_cfg_timing();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule